// File: doc/BRIEF.md
# Edge-Capturing GPIO Port

A general-purpose I/O port of one to thirty-two pins, controlled through a small word-addressed register bus with a write strobe, write data and combinational read data. Each pin carries an output value, an output-enable bit and an interrupt-enable bit. Incoming pin levels pass through a synchronizer chain, feed the data read path and, in the edge trigger modes, an edge detector. Detected edges are held in a sticky capture register that software clears by writing ones.

The trigger type is a build-time parameter: rising edge, falling edge, either edge, or level-high. In the level-high mode the capture register is absent and the interrupt follows the synchronized pin levels directly. The single interrupt output is the OR of all enabled pending bits. The block drives an output value and an output-enable per pin. The pad cells that sit outside it use these signals.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is asserted and directly after its release, `pin_out`, `pin_oe`, the enable register and the capture register are all zero, and `irq` is low.
- R2: A write to byte offset 0x4 stores the direction register. A 1 in a bit drives `pin_oe` high for that pin from the next cycle, and a 0 makes the pin an input. `pin_oe` changes only on such a write. A read of 0x4 returns the register.
- R3: A write to byte offset 0x0 sets `pin_out` from the next cycle. Write data bits at or above `NUM_PINS` are discarded.
- R4: A read of byte offset 0x0 returns the synchronized pin levels. If a pin changes just after clock edge k, the new level is seen on reads after edge k+2.
- R5: A write to byte offset 0x8 stores the interrupt-enable register. A 1 enables that pin's interrupt. A read of 0x8 returns the register.
- R6: In an edge mode, a qualifying transition sets the pin's bit in the capture register, which is read at byte offset 0xC. A pin change just after edge k is visible there after edge k+3. Rising mode uses 0-to-1 transitions, falling mode uses 1-to-0 transitions, and both mode uses either.
- R7: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R8: If an edge is detected in the same cycle that its capture bit is written with 1, the bit ends up set.
- R9: `irq` is the OR of the pending bits. In the edge modes a pending bit is capture AND enable. In level-high mode it is the synchronized level AND enable, and a read of 0xC returns zero.
- R10: Edges are captured even while the pin's enable bit is 0. The enable bit gates only `irq`.
- R11: Writes to word offsets other than the four registers change no state. Reads from them return zero. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the capture of a new edge and a write-one clear of the same bit. The bench raises a pin and then issues a clear of all bits exactly three edges later, so both act on one clock edge. It also mixes random pin toggles with random clears over a long run. A behavioural reference model applies the clear first and then the event on every edge. The capture read-back and `irq` of each trigger mode are compared with the model every cycle, so a design in which the clear wins is reported in the cycle after the collision.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // interrupt trigger selection, fixed at build time
   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_BOTH  = 2'd2,
      TRIG_LEVEL = 2'd3
   } trig_e;

   localparam int unsigned GPIO_MAX_PINS = 32;
   localparam int unsigned GPIO_BUS_W    = 32;

   // word indices (byte address >> 2)
   localparam int unsigned WIDX_DATA = 0;
   localparam int unsigned WIDX_DIR  = 1;
   localparam int unsigned WIDX_MASK = 2;
   localparam int unsigned WIDX_CAP  = 3;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter trig_e       TRIG  = TRIG_BOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,       // synchronized levels
   input  logic [WIDTH-1:0] clr,       // qualified write-one-to-clear
   output logic [WIDTH-1:0] evt,       // edge detected this cycle
   output logic [WIDTH-1:0] cap_q      // sticky capture
);
   generate
      if (TRIG == TRIG_LEVEL) begin : g_level
         logic unused_level_inputs;
         assign unused_level_inputs = ^{lvl, clr, clk, rst_n};
         assign evt   = '0;
         assign cap_q = '0;
      end else begin : g_edge
         logic [WIDTH-1:0] prev_q;
         logic [WIDTH-1:0] cap_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= lvl;
         end

         if (TRIG == TRIG_RISE) begin : g_rise
            assign evt = lvl & ~prev_q;
         end else if (TRIG == TRIG_FALL) begin : g_fall
            assign evt = ~lvl & prev_q;
         end else begin : g_both
            assign evt = lvl ^ prev_q;
         end

         // a fresh event outranks a clear of the same bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_r <= '0;
            else        cap_r <= (cap_r & ~clr) | evt;
         end
         assign cap_q = cap_r;
      end
   endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [GPIO_BUS_W-1:0] bus_wdata,
   output logic [GPIO_BUS_W-1:0] bus_rdata,
   input  logic [WIDTH-1:0]      lvl,
   input  logic [WIDTH-1:0]      cap_q,
   output logic [WIDTH-1:0]      out_q,
   output logic [WIDTH-1:0]      dir_q,
   output logic [WIDTH-1:0]      mask_q,
   output logic [WIDTH-1:0]      clr
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              hit_data, hit_dir, hit_mask, hit_cap;
   logic [WIDTH-1:0]  wfield;
   logic              unused_addr_lo;

   assign word           = bus_addr[ADDR_W-1:2];
   assign unused_addr_lo = ^bus_addr[1:0];
   assign wfield         = bus_wdata[WIDTH-1:0];

   generate
      if (WIDTH < GPIO_BUS_W) begin : g_wpad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[GPIO_BUS_W-1:WIDTH];
      end
   endgenerate

   assign hit_data = (word == WORD_W'(WIDX_DATA));
   assign hit_dir  = (word == WORD_W'(WIDX_DIR));
   assign hit_mask = (word == WORD_W'(WIDX_MASK));
   assign hit_cap  = (word == WORD_W'(WIDX_CAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
      end else if (bus_we) begin
         if (hit_data) out_q  <= wfield;
         if (hit_dir)  dir_q  <= wfield;
         if (hit_mask) mask_q <= wfield;
      end
   end

   assign clr = (bus_we && hit_cap) ? wfield : '0;

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         hit_data: bus_rdata[WIDTH-1:0] = lvl;
         hit_dir:  bus_rdata[WIDTH-1:0] = dir_q;
         hit_mask: bus_rdata[WIDTH-1:0] = mask_q;
         hit_cap:  bus_rdata[WIDTH-1:0] = cap_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter trig_e       TRIG        = TRIG_BOTH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > GPIO_MAX_PINS) begin : g_bad_pins
         $error("gpio_edge_port: NUM_PINS out of range 1..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("gpio_edge_port: ADDR_W must be at least 4");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_lvl;
   logic [NUM_PINS-1:0] edge_evt;
   logic [NUM_PINS-1:0] cap_q;
   logic [NUM_PINS-1:0] clr;
   logic [NUM_PINS-1:0] out_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] pending;

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_lvl)
   );

   gpio_edge_capture #(.WIDTH(NUM_PINS), .TRIG(TRIG)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_lvl),
      .clr   (clr),
      .evt   (edge_evt),
      .cap_q (cap_q)
   );

   gpio_port_regs #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .lvl       (pin_lvl),
      .cap_q     (cap_q),
      .out_q     (out_q),
      .dir_q     (dir_q),
      .mask_q    (mask_q),
      .clr       (clr)
   );

   generate
      if (TRIG == TRIG_LEVEL) begin : g_pend_level
         assign pending = pin_lvl & mask_q;
      end else begin : g_pend_edge
         assign pending = cap_q & mask_q;
      end
   endgenerate

   assign irq     = |pending;
   assign pin_out = out_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
   import gpio_edge_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 5,
   parameter trig_e       TRIG   = TRIG_BOTH
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic [W-1:0]      pin_out,
   input logic [W-1:0]      pin_oe,
   input logic              irq,
   input logic [W-1:0]      mask_q,
   input logic [W-1:0]      cap_q,
   input logic [W-1:0]      evt
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              wr_data, wr_dir, wr_cap;
   logic [W-1:0]      wf;

   assign word    = bus_addr[ADDR_W-1:2];
   assign wr_data = bus_we && (word == WORD_W'(WIDX_DATA));
   assign wr_dir  = bus_we && (word == WORD_W'(WIDX_DIR));
   assign wr_cap  = bus_we && (word == WORD_W'(WIDX_CAP));
   assign wf      = bus_wdata[W-1:0];

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && pin_oe == '0 && pin_out == '0)); // R1

   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (pin_oe == $past(wf))); // R2

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(pin_oe)); // R2

   AST_DATA_TO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (pin_out == $past(wf))); // R3

   AST_CAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_q & ~$past(cap_q) & ~$past(evt)) == '0); // R6

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cap |=> ((cap_q & $past(wf) & ~$past(evt)) == '0)); // R7

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((cap_q & $past(evt)) == $past(evt))); // R8

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R9
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
   .W      (NUM_PINS),
   .ADDR_W (ADDR_W),
   .TRIG   (TRIG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .mask_q    (mask_q),
   .cap_q     (cap_q),
   .evt       (edge_evt)
);

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;
   import gpio_edge_pkg::*;

   localparam int NP = 8;
   localparam int AW = 5;
   localparam int NI = 4; // 0 both, 1 rise, 2 fall, 3 level

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk; // 125 MHz

   logic [AW-1:0] addr  = '0;
   logic          we    = 1'b0;
   logic [31:0]   wdata = '0;
   logic [NP-1:0] pins  = '0;

   logic [NI-1:0]           irq_v;
   logic [NI-1:0][31:0]     rd_v;
   logic [NI-1:0][NP-1:0]   out_v;
   logic [NI-1:0][NP-1:0]   oe_v;

   gpio_edge_port #(.NUM_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_BOTH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_v[0]), .pin_in(pins), .pin_out(out_v[0]), .pin_oe(oe_v[0]), .irq(irq_v[0]));
   gpio_edge_port #(.NUM_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_RISE)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_v[1]), .pin_in(pins), .pin_out(out_v[1]), .pin_oe(oe_v[1]), .irq(irq_v[1]));
   gpio_edge_port #(.NUM_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_FALL)) u2 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_v[2]), .pin_in(pins), .pin_out(out_v[2]), .pin_oe(oe_v[2]), .irq(irq_v[2]));
   gpio_edge_port #(.NUM_PINS(NP), .ADDR_W(AW), .TRIG(TRIG_LEVEL)) u3 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_v[3]), .pin_in(pins), .pin_out(out_v[3]), .pin_oe(oe_v[3]), .irq(irq_v[3]));

   int checks   = 0;
   int failures = 0;
   string ph = "R1";

   // ---------------- reference model ----------------
   logic [NP-1:0] hist[$];
   logic [NP-1:0] m_out, m_dir, m_mask;
   logic [NP-1:0] m_cap[NI];

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{'0, '0, '0};
         m_out = '0; m_dir = '0; m_mask = '0;
         for (int i = 0; i < NI; i++) m_cap[i] = '0;
      end else begin
         logic [NP-1:0] lv, pv, clr, ev;
         int wd;
         lv  = hist[hist.size()-2];
         pv  = hist[hist.size()-3];
         wd  = int'(addr) >> 2;
         clr = (we && wd == 3) ? wdata[NP-1:0] : '0;
         for (int i = 0; i < NI; i++) begin
            case (i)
               0: ev = lv ^ pv;
               1: ev = lv & ~pv;
               2: ev = ~lv & pv;
               default: ev = '0;
            endcase
            m_cap[i] = (i == 3) ? '0 : ((m_cap[i] & ~clr) | ev);
         end
         if (we && wd == 0) m_out  = wdata[NP-1:0];
         if (we && wd == 1) m_dir  = wdata[NP-1:0];
         if (we && wd == 2) m_mask = wdata[NP-1:0];
         hist.push_back(pins);
         if (hist.size() > 4) void'(hist.pop_front());
      end
   end

   task automatic check(input bit ok, input string tag, input int inst,
                        input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s u%0d %s act=%h exp=%h (phase %s)", tag, inst, what, act, exp, ph);
      end
   endtask

   always @(negedge clk) begin
      if (hist.size() >= 3) begin
         logic [NP-1:0] lv;
         logic [31:0] er;
         int wd;
         string rtag;
         lv = hist[hist.size()-2];
         wd = int'(addr) >> 2;
         for (int i = 0; i < NI; i++) begin
            er = '0;
            case (wd)
               0: begin er[NP-1:0] = lv;        rtag = "R4";  end
               1: begin er[NP-1:0] = m_dir;     rtag = "R2";  end
               2: begin er[NP-1:0] = m_mask;    rtag = "R5";  end
               3: begin er[NP-1:0] = m_cap[i];  rtag = (i == 3) ? "R9" : "R6"; end
               default: begin er = '0;          rtag = "R11"; end
            endcase
            check(rd_v[i] === er, rtag, i, "rdata", rd_v[i], er);
            check(out_v[i] === m_out, "R3", i, "pin_out", 32'(out_v[i]), 32'(m_out));
            check(oe_v[i] === m_dir, "R2", i, "pin_oe", 32'(oe_v[i]), 32'(m_dir));
            check(irq_v[i] === ((i == 3) ? |(lv & m_mask) : |(m_cap[i] & m_mask)),
                  "R9", i, "irq", 32'(irq_v[i]),
                  32'((i == 3) ? |(lv & m_mask) : |(m_cap[i] & m_mask)));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      repeat (n) step();
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      step();
      we = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset values
      ph = "R1";
      idle(4);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) begin addr = AW'(a * 4); step(); end

      // R2, R3: direction and output values, upper data bits dropped
      ph = "R2_R3";
      wr(5'h04, 32'h0000_00F0);
      addr = 5'h04; step();
      wr(5'h00, 32'h0000_00A5);
      wr(5'h00, 32'hFFFF_FF3C);
      wr(5'h04, 32'h0000_000F);
      idle(2);

      // R4: pin levels through the synchronizer
      ph = "R4";
      addr = 5'h00;
      pins = 8'h5A; idle(3);
      pins = 8'hC3; idle(3);

      // R10: edges captured while every pin is disabled
      ph = "R10";
      addr = 5'h0C;
      pins = 8'h00; idle(4);
      pins = 8'hFF; idle(4);
      wr(5'h0C, 32'hFFFF_FFFF); idle(1);

      // R5: enable register
      ph = "R5";
      wr(5'h08, 32'h0000_00FF);
      addr = 5'h08; step();

      // R6: rising and falling edges per mode
      ph = "R6";
      addr = 5'h0C;
      pins = 8'h0F; idle(4);
      pins = 8'hF0; idle(4);

      // R7: write-one clears, zeros keep
      ph = "R7";
      wr(5'h0C, 32'h0000_000F); idle(1);
      wr(5'h0C, 32'h0000_0000); idle(1);
      wr(5'h0C, 32'h0000_00FF); idle(1);

      // R8: edge and clear on the same clock edge
      ph = "R8";
      pins = 8'hF1; step(); step();
      wr(5'h0C, 32'hFFFF_FFFF); idle(2);
      pins = 8'hF0; step(); step();
      wr(5'h0C, 32'h0000_0001); idle(2);

      // R9: enable gating of irq, level mode follows pins
      ph = "R9";
      wr(5'h08, 32'h0000_0001); idle(2);
      wr(5'h08, 32'h0000_0000); idle(2);
      wr(5'h08, 32'h0000_0080); idle(2);
      pins = 8'h70; idle(4);
      wr(5'h0C, 32'h0000_00FF); idle(2);

      // R11: unused word offsets and low address bits
      ph = "R11";
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h1C, 32'h0000_00FF);
      addr = 5'h14; step();
      wr(5'h05, 32'h0000_0033);
      addr = 5'h07; step();
      addr = 5'h1A; step();

      // mixed random traffic including clear/edge collisions
      ph = "RAND_R8";
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 2) == 0) pins = NP'($urandom);
         if ($urandom_range(0, 3) == 0)
            wr(AW'($urandom_range(0, 31)), $urandom);
         else begin
            addr = AW'($urandom_range(0, 31));
            step();
         end
      end
      idle(2);
      finish_run();
   end
endmodule